// File: doc/BRIEF.md
# Predictive Synchronous-Rectifier Gate Timer

This block produces the gate-enable level for the synchronous rectifier switch on the secondary side of a flyback converter. A sync clock taken from the transformer secondary tells it when to act. The gate is switched on when that clock falls. It is switched off a chosen number of timing ticks before the clock is expected to rise again. That expected rise is predicted from the length of the previous low phase, which the block measures in ticks of a free-running strobe. The rectifier is therefore already off when the primary switch turns back on, rather than reacting to the edge only after it has arrived.

The phase counter restarts on every accepted clock edge, so all timing is realigned to the sync clock in each cycle. A reverse-current input cuts the gate short once a minimum on time has passed, which allows discontinuous conduction. A duty monitor with hysteresis stops driving at very light load. Clock pulses that are too short to be real edges are filtered out. If the clock stops, the phase counter saturates and the gate is held low until a full clean period has been measured again.

Top module: `srg_gate_timer`

## Requirements
- R1: While reset is asserted, and after its release until a fall, a rise and a second fall of the filtered sync clock have all been seen, gate_o is low. The first low phase after reset produces no gate pulse.
- R2: gate_o rises only in the clock cycle that follows a filtered falling edge of sync_clk_i.
- R3: In a steady cycle, gate_o stays high for (previous low-phase length in ticks) minus the anticipation. ant_sel_i codes 1, 2 and 3 give 1, 2 and 3 ticks (times ANT_STEP), and code 0 acts as 1. The length measured in one cycle sets the turn-off point of the next cycle.
- R4: The predicted on time is never shorter than MIN_ON_TICKS (default 4). If the gate drops for any reason other than a clock rise or a lost clock, it has been high for at least that many ticks.
- R5: A filtered rising edge of sync_clk_i drives gate_o low in the next cycle. This happens even if the predicted turn-off or the minimum on time has not yet been reached.
- R6: When inhibit_i is high (reverse current, active high), gate_o goes low as soon as it has been high for MIN_ON_TICKS. It stays low until the next falling edge.
- R7: A change of the sync clock level is accepted only after it has held for FILT_TICKS consecutive ticks (default 2). A single-tick pulse in either phase is ignored and does not change the measured low length.
- R8: A period counts as high time plus low time. When the sync clock's high time falls below DUTY_OFF_PCT (13) percent of its period, no gate pulse is issued from the falling edge that ends that period.
- R9: Once driving is off, it resumes only after a period whose high time exceeds DUTY_ON_PCT (18) percent. Between the two thresholds, the previous state holds.
- R10: The phase counter saturates at 2^CNT_W-1 (255) ticks. A saturated phase counts as a lost clock: gate_o is held low, and one complete clean period must follow before pulses start again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe of the free-running timing tick |
| sync_clk_i | input | 1 | Asynchronous sync clock from the transformer secondary |
| inhibit_i | input | 1 | Asynchronous reverse-current flag, active high |
| ant_sel_i | input | 2 | Anticipation code (0 and 1: 1 step, 2: 2 steps, 3: 3 steps) |
| gate_o | output | 1 | Gate enable for the synchronous rectifier switch |

## Verification
The assertions rely on a few properties of the inputs: the accepted clock edges alternate, at most one tick happens per system clock, and a low phase never lasts long enough for the predicted turn-off to wrap the counter. The bench asserts tick_i in every cycle, so one tick equals one clock. It holds every clock level for at least three cycles, except for the deliberate one-cycle glitches. It changes ant_sel_i and inhibit_i only during the high phase, so the code sampled at the falling edge is always well defined.

// File: rtl/srg_pkg.sv
`timescale 1ns/1ps
package srg_pkg;
  typedef enum logic {
    GS_IDLE  = 1'b0,
    GS_DRIVE = 1'b1
  } gate_state_e;

  typedef struct packed {
    logic fall;
    logic rise;
  } edge_ev_t;

  localparam int ANT_SEL_W = 2;
endpackage

// File: rtl/srg_sync.sv
`timescale 1ns/1ps
module srg_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/srg_edge_filter.sv
`timescale 1ns/1ps
module srg_edge_filter
  import srg_pkg::*;
#(
  parameter int STABLE_TICKS = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick_i,
  input  logic     raw_i,
  output edge_ev_t ev_o
);
  localparam int SW = $clog2(STABLE_TICKS + 1);
  localparam logic [SW-1:0] LAST = SW'(STABLE_TICKS - 1);

  logic          level_q;
  logic [SW-1:0] hold_q;
  logic          rise_q, fall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      hold_q  <= '0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if (tick_i) begin
        if (raw_i == level_q) begin
          hold_q <= '0;
        end else if (hold_q == LAST) begin
          level_q <= raw_i;
          hold_q  <= '0;
          rise_q  <= raw_i;
          fall_q  <= ~raw_i;
        end else begin
          hold_q <= hold_q + 1'b1;
        end
      end
    end
  end

  assign ev_o.fall = fall_q;
  assign ev_o.rise = rise_q;
endmodule

// File: rtl/srg_period_meter.sv
`timescale 1ns/1ps
module srg_period_meter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             fall_ev_i,
  input  logic             rise_ev_i,
  output logic [CNT_W-1:0] phase_cnt_o,
  output logic [CNT_W-1:0] low_len_o,
  output logic             sat_o,
  output logic             period_ok_o
);
  localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};

  logic [CNT_W-1:0] ph_q, low_q;
  logic             seen_fall_q, low_ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q        <= '0;
      low_q       <= '0;
      seen_fall_q <= 1'b0;
      low_ok_q    <= 1'b0;
    end else if (fall_ev_i) begin
      ph_q        <= CNT_W'(1);
      seen_fall_q <= 1'b1;
    end else if (rise_ev_i) begin
      ph_q     <= CNT_W'(1);
      low_q    <= ph_q;
      low_ok_q <= seen_fall_q && (ph_q != MAXC);
    end else if (tick_i && (ph_q != MAXC)) begin
      ph_q <= ph_q + 1'b1;
    end
  end

  assign phase_cnt_o = ph_q;
  assign low_len_o   = low_q;
  assign sat_o       = (ph_q == MAXC);
  assign period_ok_o = fall_ev_i && low_ok_q && (ph_q != MAXC);
endmodule

// File: rtl/srg_duty_monitor.sv
`timescale 1ns/1ps
module srg_duty_monitor #(
  parameter int CNT_W   = 8,
  parameter int OFF_PCT = 13,
  parameter int ON_PCT  = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval_i,
  input  logic [CNT_W-1:0] high_len_i,
  input  logic [CNT_W-1:0] low_len_i,
  output logic             en_nxt_o
);
  localparam int PW = CNT_W + 1;
  localparam int MW = CNT_W + 8;

  logic          en_q;
  logic [PW-1:0] period_w;
  logic [MW-1:0] hi_scaled, off_lim, on_lim;

  always_comb begin
    period_w  = {1'b0, low_len_i} + {1'b0, high_len_i};
    hi_scaled = MW'(high_len_i) * MW'(100);
    off_lim   = MW'(period_w) * MW'(OFF_PCT);
    on_lim    = MW'(period_w) * MW'(ON_PCT);
    en_nxt_o  = en_q;
    if (eval_i) begin
      if (en_q) en_nxt_o = !(hi_scaled < off_lim);
      else      en_nxt_o = (hi_scaled > on_lim);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b1;
    else        en_q <= en_nxt_o;
  end
endmodule

// File: rtl/srg_gate_ctrl.sv
`timescale 1ns/1ps
module srg_gate_ctrl
  import srg_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int MIN_ON   = 4,
  parameter int ANT_STEP = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 fall_ev_i,
  input  logic                 rise_ev_i,
  input  logic                 start_ok_i,
  input  logic                 sat_i,
  input  logic                 inhibit_i,
  input  logic [ANT_SEL_W-1:0] ant_sel_i,
  input  logic [CNT_W-1:0]     low_len_i,
  output logic                 gate_o,
  output logic [CNT_W-1:0]     on_cnt_o
);
  localparam int XW = CNT_W + 1;
  localparam logic [CNT_W-1:0] MAXC  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_ON);
  localparam logic [XW-1:0]    MIN_X = XW'(MIN_ON);

  gate_state_e          state_q;
  logic [CNT_W-1:0]     on_q, tgt_q, tgt_c;
  logic [XW-1:0]        ant_x, low_x;
  logic [ANT_SEL_W-1:0] code_eff;

  always_comb begin
    code_eff = (ant_sel_i == '0) ? ANT_SEL_W'(1) : ant_sel_i;
    ant_x    = XW'(code_eff) * XW'(ANT_STEP);
    low_x    = {1'b0, low_len_i};
    if (low_x >= ant_x + MIN_X) tgt_c = CNT_W'(low_x - ant_x);
    else                        tgt_c = MIN_C;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GS_IDLE;
      on_q    <= '0;
      tgt_q   <= '0;
    end else if (fall_ev_i) begin
      if (start_ok_i) begin
        state_q <= GS_DRIVE;
        on_q    <= CNT_W'(1);
        tgt_q   <= tgt_c;
      end else begin
        state_q <= GS_IDLE;
      end
    end else if (state_q == GS_DRIVE) begin
      if (rise_ev_i || sat_i) begin
        state_q <= GS_IDLE;
      end else if (tick_i) begin
        if ((on_q >= tgt_q) || (inhibit_i && (on_q >= MIN_C))) state_q <= GS_IDLE;
        else if (on_q != MAXC) on_q <= on_q + 1'b1;
      end
    end
  end

  assign gate_o   = (state_q == GS_DRIVE);
  assign on_cnt_o = on_q;
endmodule

// File: rtl/srg_gate_timer.sv
`timescale 1ns/1ps
module srg_gate_timer
  import srg_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int FILT_TICKS   = 2,
  parameter int SYNC_STAGES  = 2,
  parameter int MIN_ON_TICKS = 4,
  parameter int ANT_STEP     = 1,
  parameter int DUTY_OFF_PCT = 13,
  parameter int DUTY_ON_PCT  = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 sync_clk_i,
  input  logic                 inhibit_i,
  input  logic [ANT_SEL_W-1:0] ant_sel_i,
  output logic                 gate_o
);
  logic [1:0]       async_in, synced;
  logic             sclk_s, inh_s;
  edge_ev_t         ev;
  logic             fall_ev, rise_ev;
  logic [CNT_W-1:0] phase_cnt, low_len, on_cnt;
  logic             sat, period_ok, duty_en, start_ok;

  assign async_in = {inhibit_i, sync_clk_i};

  srg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(async_in), .q_o(synced)
  );
  assign sclk_s = synced[0];
  assign inh_s  = synced[1];

  srg_edge_filter #(.STABLE_TICKS(FILT_TICKS)) u_filt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .raw_i(sclk_s), .ev_o(ev)
  );
  assign fall_ev = ev.fall;
  assign rise_ev = ev.rise;

  srg_period_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .fall_ev_i(fall_ev), .rise_ev_i(rise_ev),
    .phase_cnt_o(phase_cnt), .low_len_o(low_len),
    .sat_o(sat), .period_ok_o(period_ok)
  );

  srg_duty_monitor #(.CNT_W(CNT_W), .OFF_PCT(DUTY_OFF_PCT), .ON_PCT(DUTY_ON_PCT)) u_duty (
    .clk(clk), .rst_n(rst_n), .eval_i(period_ok),
    .high_len_i(phase_cnt), .low_len_i(low_len), .en_nxt_o(duty_en)
  );
  assign start_ok = period_ok && duty_en;

  srg_gate_ctrl #(.CNT_W(CNT_W), .MIN_ON(MIN_ON_TICKS), .ANT_STEP(ANT_STEP)) u_gate (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .fall_ev_i(fall_ev), .rise_ev_i(rise_ev), .start_ok_i(start_ok),
    .sat_i(sat), .inhibit_i(inh_s), .ant_sel_i(ant_sel_i),
    .low_len_i(low_len), .gate_o(gate_o), .on_cnt_o(on_cnt)
  );
endmodule

// File: rtl/srg_gate_timer_chk.sv
`timescale 1ns/1ps
module srg_gate_timer_chk #(
  parameter int CNT_W  = 8,
  parameter int MIN_ON = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             gate_o,
  input logic             fall_ev,
  input logic             rise_ev,
  input logic             sat,
  input logic             inh_s,
  input logic [CNT_W-1:0] on_cnt
);
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_ON);

  AST_ON_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> $past(fall_ev)); // R2

  AST_RISE_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |=> !gate_o); // R5

  AST_MIN_ON_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate_o) && !$past(rise_ev) && !$past(sat)) |-> ($past(on_cnt) >= MIN_C)); // R4

  AST_INHIBIT_CUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && inh_s && gate_o && (on_cnt >= MIN_C)) |=> !gate_o); // R6

  AST_LOST_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sat |=> !gate_o); // R10
endmodule

bind srg_gate_timer srg_gate_timer_chk #(.CNT_W(CNT_W), .MIN_ON(MIN_ON_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .gate_o(gate_o),
  .fall_ev(fall_ev), .rise_ev(rise_ev), .sat(sat), .inh_s(inh_s), .on_cnt(on_cnt)
);

// File: tb/srg_gate_timer_tb.sv
`timescale 1ns/1ps
module srg_gate_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       sclk = 1'b1;
  logic       inh = 1'b0;
  logic [1:0] ant = 2'd1;
  logic       gate;

  int nchk = 0, nerr = 0;
  int run_len = 0, last_len = 0, bursts = 0, high_seen = 0;
  logic prev_gate = 1'b0;

  always #2.5 clk = ~clk;

  srg_gate_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .sync_clk_i(sclk),
    .inhibit_i(inh), .ant_sel_i(ant), .gate_o(gate)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      run_len = 0; prev_gate = 1'b0;
    end else begin
      if (gate) begin run_len++; high_seen = 1; end
      if (prev_gate && !gate) begin bursts++; last_len = run_len; run_len = 0; end
      prev_gate = gate;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    @(negedge clk);
    bursts = 0; last_len = 0; high_seen = 0;
  endtask

  task automatic period(input int lo, input int hi);
    @(negedge clk) sclk = 1'b0;
    repeat (lo - 1) @(negedge clk);
    @(negedge clk) sclk = 1'b1;
    repeat (hi - 1) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sclk = 1'b1; inh = 1'b0; ant = 2'd1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic warm(input int lo, input int hi);
    do_reset();
    period(lo, hi);
    period(lo, hi);
    clr();
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 gate low in reset", int'(gate), 0);
    rst_n = 1'b1; sclk = 1'b1;
    repeat (20) @(negedge clk);
    clr();
    period(40, 40);
    chk("R1 no pulse before full period", bursts, 0);
    period(40, 40);
    chk("R1 first pulse after full period", bursts, 1);
    chk("R3 first pulse length", last_len, 39);
  endtask

  task automatic t_anticip();
    warm(40, 40);
    for (int c = 0; c < 4; c++) begin
      ant = 2'(c);
      clr();
      period(40, 40);
      chk("R3 anticipation code length", last_len, 40 - ((c == 0) ? 1 : c));
      chk("R3 one pulse per period", bursts, 1);
    end
  endtask

  task automatic t_floor();
    do_reset();
    ant = 2'd3;
    period(5, 40); period(5, 40);
    clr();
    period(5, 40);
    chk("R4 floored on time", last_len, 4);
    clr();
    period(3, 40);
    chk("R5 rise cuts below floor", last_len, 3);
  endtask

  task automatic t_early();
    warm(60, 40);
    clr();
    period(60, 40);
    chk("R3 steady long low", last_len, 59);
    clr();
    period(25, 40);
    chk("R5 early rise forces off", last_len, 25);
    clr();
    period(25, 40);
    chk("R3 prediction adapts", last_len, 24);
  endtask

  task automatic t_inhibit();
    warm(40, 40);
    inh = 1'b1;
    clr();
    period(40, 40);
    chk("R6 inhibit cuts at min on", last_len, 4);
    chk("R6 no re-turn-on", bursts, 1);
    inh = 1'b0;
    clr();
    period(40, 40);
    chk("R6 normal after inhibit", last_len, 39);
  endtask

  task automatic t_glitch();
    warm(40, 40);
    clr();
    @(negedge clk) sclk = 1'b0;
    repeat (19) @(negedge clk);
    sclk = 1'b1;
    @(negedge clk) sclk = 1'b0;
    repeat (19) @(negedge clk);
    @(negedge clk) sclk = 1'b1;
    repeat (19) @(negedge clk);
    sclk = 1'b0;
    @(negedge clk) sclk = 1'b1;
    repeat (19) @(negedge clk);
    chk("R7 glitch in low ignored", last_len, 39);
    chk("R7 no extra pulse", bursts, 1);
    clr();
    period(40, 40);
    chk("R7 glitch not measured", last_len, 39);
  endtask

  task automatic t_duty();
    warm(50, 50);
    repeat (3) period(90, 10);
    clr();
    repeat (3) period(90, 10);
    chk("R8 shut below low threshold", bursts, 0);
    clr();
    repeat (3) period(85, 15);
    chk("R9 stays off between thresholds", bursts, 0);
    clr();
    repeat (3) period(75, 25);
    chk("R9 resumes above high threshold", bursts, 2);
    clr();
    repeat (3) period(85, 15);
    chk("R9 stays on between thresholds", bursts, 3);
  endtask

  task automatic t_lost();
    warm(40, 40);
    period(40, 40);
    clr();
    repeat (300) @(negedge clk);
    chk("R10 gate low while clock stuck", high_seen, 0);
    clr();
    repeat (3) period(40, 40);
    chk("R10 one clean period before restart", bursts, 2);
    chk("R10 length after restart", last_len, 39);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    t_reset();
    t_anticip();
    t_floor();
    t_early();
    t_inhibit();
    t_glitch();
    t_duty();
    t_lost();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule